// File: doc/BRIEF.md
# Time-Triggered Output Waveform Generator

This block drives one output pin with a waveform that starts at a chosen instant of a shared nanosecond time base. Software loads a target time, a waveform code and the widths, count and bit pattern the waveform needs, then pulses an arm strobe. The unit latches that setup, waits until the system time reaches the target, and then plays the waveform: a lone edge, a lone pulse, a train of periodic pulses, or a 16-bit word sent out serially in a loop.

Widths are given in nanoseconds and measured against the per-clock advance of the time base, so a phase of `w` ns holds the pin for `ceil(w / STEP_NS)` clocks. Widths below the toggle-rate floor are raised to it. A done flag marks the end of a finite waveform and an error flag marks a target that had already passed at arming. A notify bit decides whether either flag may be raised. A software reset abandons the waveform and parks the pin at the idle level.

Top module: `trig_wavegen`

## Requirements
- R1: After `rst`, `pin_out`, `trig_done` and `trig_err` are all 0.
- R2: Arming with a valid code drives the pin to the idle level of that code in the next clock. The idle level is high for codes 000, 010 and 100 and low for 001, 011, 101 and 110. The waveform's first edge is driven at the first clock edge at which the system time is greater than or equal to the target.
- R3: Code 000 drives the pin low at the trigger and keeps it low. Code 001 drives it high and keeps it high. With notify set, `trig_done` rises in the same clock as the edge.
- R4: Codes 010 and 011 give one pulse (low or high) of the pulse width, lasting `ceil(w/STEP_NS)` clocks, then return to idle. `trig_done` rises with the return edge.
- R5: Codes 100 and 101 repeat a period of the cycle width. The period starts with an active phase of the pulse width (low for 100, high for 101), followed by the idle level for the rest. With a count of N greater than 0, the pin returns to idle at the end of the N-th active phase and `trig_done` rises.
- R6: Code 110 sends the pattern word least significant bit first, wrapping to bit 0 after the top bit. Each bit is held for the cycle width. After the count of bits the pin goes low and `trig_done` rises.
- R7: A count of 0 in codes 100, 101 and 110 makes the waveform run until re-armed or reset, and `trig_done` stays 0.
- R8: With the immediate bit set and a target earlier than the system time at arming, the waveform starts at the next clock edge.
- R9: With the immediate bit clear and a target earlier than the system time at arming, the pin stays idle, no waveform is produced, and `trig_err` rises if notify is set.
- R10: With notify clear, neither `trig_done` nor `trig_err` is ever raised.
- R11: Each phase is at least `MIN_W_NS` long: pulse width and pattern bit width are raised to `MIN_W_NS`. The periodic cycle width is raised to the clamped pulse width plus `MIN_W_NS`.
- R12: `sw_rst` stops the unit, clears both flags and sets the pin to the idle level of `cfg_mode` on the next clock. It wins over `arm` in the same cycle.
- R13: Arming with the reserved code 111 is ignored: the pin, the flags and any waveform in progress are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_time | input | TW | Free-running system time in ns |
| tgt_time | input | TW | Target time, latched at arming |
| cfg_mode | input | 3 | Waveform code |
| cfg_now | input | 1 | Fire at once if the target has already passed |
| cfg_notify | input | 1 | Allow the done and error flags |
| pulse_w | input | WW | Active phase width in ns |
| cycle_w | input | WW | Period or bit width in ns |
| cyc_count | input | CW | Number of periods or bits, 0 means unlimited |
| pat_word | input | PATW | Serial pattern word |
| arm | input | 1 | One-cycle strobe that latches the setup and arms the unit |
| sw_rst | input | 1 | Software stop and flag clear |
| pin_out | output | 1 | Waveform output |
| trig_done | output | 1 | Finite waveform or edge completed |
| trig_err | output | 1 | Target already passed at arming, no fire |

## Verification
The bench builds the unit with `STEP_NS = 10`, so the time base moves by one 100 MHz period per clock and every width maps onto a whole number of clocks that can be counted sample by sample. It keeps `MIN_W_NS = 40`, so a requested width of 10 or 30 ns shows up as a four-clock phase, and the periodic floor of pulse plus 40 ns becomes visible as an eight-clock period. The time base and pattern keep their full 64-bit and 16-bit defaults, so a 20-bit serial run wraps past the top of the word.

// File: rtl/trig_pkg.sv
`timescale 1ns/1ps
package trig_pkg;

    typedef enum logic [2:0] {
        WV_FALL    = 3'b000,
        WV_RISE    = 3'b001,
        WV_LOPULSE = 3'b010,
        WV_HIPULSE = 3'b011,
        WV_LOCYCLE = 3'b100,
        WV_HICYCLE = 3'b101,
        WV_SERIAL  = 3'b110,
        WV_RSVD    = 3'b111
    } wave_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } seq_st_e;

    // Setup fields held for the life of one armed waveform
    typedef struct packed {
        wave_e mode;
        logic  notify;
        logic  endless;
    } arm_cfg_t;

    // Resting level of the pin for a waveform code
    function automatic logic idle_level(input wave_e m);
        case (m)
            WV_FALL, WV_LOPULSE, WV_LOCYCLE: return 1'b1;
            default:                         return 1'b0;
        endcase
    endfunction

    function automatic logic is_pulse(input wave_e m);
        return (m == WV_LOPULSE) || (m == WV_HIPULSE);
    endfunction

    function automatic logic is_cycle(input wave_e m);
        return (m == WV_LOCYCLE) || (m == WV_HICYCLE);
    endfunction

endpackage

// File: rtl/trig_time_cmp.sv
`timescale 1ns/1ps
module trig_time_cmp #(
    parameter int TW = 64
) (
    input  logic [TW-1:0] sys_time,
    input  logic [TW-1:0] tgt_live,
    input  logic [TW-1:0] tgt_held,
    output logic          reached,
    output logic          late
);
    // reached: the armed target has come; late: the offered target is already behind
    always_comb begin
        reached = (sys_time >= tgt_held);
        late    = (tgt_live <  sys_time);
    end
endmodule

// File: rtl/trig_phase_timer.sv
`timescale 1ns/1ps
module trig_phase_timer #(
    parameter int WW       = 32,
    parameter int STEP_NS  = 8,
    parameter int MIN_W_NS = 40
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic [WW-1:0] ld_width,
    output logic          expire
);
    localparam logic [WW-1:0] STEP_V = WW'(STEP_NS);
    localparam logic [WW-1:0] MIN_V  = WW'(MIN_W_NS);

    logic [WW-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (rst)                 rem_q <= '0;
        else if (ld)             rem_q <= ld_width;
        else if (rem_q > STEP_V) rem_q <= rem_q - STEP_V;
    end

    // The phase ends in the clock whose advance covers the remaining time
    assign expire = (rem_q <= STEP_V);

    // R11
    min_width_chk: assert property (@(posedge clk) disable iff (rst)
        ld |-> (ld_width >= MIN_V));
endmodule

// File: rtl/trig_seq_fsm.sv
`timescale 1ns/1ps
module trig_seq_fsm
    import trig_pkg::*;
#(
    parameter int TW       = 64,
    parameter int WW       = 32,
    parameter int CW       = 16,
    parameter int PATW     = 16,
    parameter int MIN_W_NS = 40
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            arm,
    input  logic            sw_rst,
    input  logic [2:0]      cfg_mode,
    input  logic            cfg_now,
    input  logic            cfg_notify,
    input  logic [TW-1:0]   tgt_time,
    input  logic [WW-1:0]   pulse_w,
    input  logic [WW-1:0]   cycle_w,
    input  logic [CW-1:0]   cyc_count,
    input  logic [PATW-1:0] pat_word,
    input  logic            late,
    input  logic            reached,
    input  logic            expire,
    output logic [TW-1:0]   tgt_held,
    output logic            ld,
    output logic [WW-1:0]   ld_width,
    output logic            pin,
    output logic            done,
    output logic            err
);
    localparam int            IW    = (PATW > 1) ? $clog2(PATW) : 1;
    localparam logic [IW-1:0] LAST  = IW'(PATW - 1);
    localparam logic [WW-1:0] MIN_V = WW'(MIN_W_NS);

    seq_st_e        st_q,   st_d;
    arm_cfg_t       cfg_q,  cfg_d;
    logic           act_q,  act_d;
    logic [CW-1:0]  cnt_q,  cnt_d;
    logic [IW-1:0]  idx_q,  idx_d;
    logic [PATW-1:0] pat_q, pat_d;
    logic [WW-1:0]  pw_q,   pw_d;
    logic [WW-1:0]  cw_q,   cw_d;
    logic [TW-1:0]  tgt_q,  tgt_d;
    logic           pin_q,  pin_d;
    logic           done_q, done_d;
    logic           err_q,  err_d;

    wave_e mode_in;
    logic  act_lvl, idle_lvl, last_unit;
    logic [WW-1:0] pw_c, cw_floor, cw_c;

    always_comb begin
        mode_in   = wave_e'(cfg_mode);
        idle_lvl  = idle_level(cfg_q.mode);
        act_lvl   = ~idle_lvl;
        last_unit = !cfg_q.endless && (cnt_q == CW'(1));
        // Width floors applied once at arming
        pw_c      = (pulse_w < MIN_V) ? MIN_V : pulse_w;
        cw_floor  = (mode_in == WV_SERIAL) ? MIN_V : (pw_c + MIN_V);
        cw_c      = (cycle_w < cw_floor) ? cw_floor : cycle_w;
    end

    always_comb begin
        st_d     = st_q;
        cfg_d    = cfg_q;
        act_d    = act_q;
        cnt_d    = cnt_q;
        idx_d    = idx_q;
        pat_d    = pat_q;
        pw_d     = pw_q;
        cw_d     = cw_q;
        tgt_d    = tgt_q;
        pin_d    = pin_q;
        done_d   = done_q;
        err_d    = err_q;
        ld       = 1'b0;
        ld_width = pw_q;

        if (sw_rst) begin
            st_d   = ST_IDLE;
            pin_d  = idle_level(mode_in);
            done_d = 1'b0;
            err_d  = 1'b0;
        end else if (arm && (mode_in != WV_RSVD)) begin
            cfg_d  = '{mode: mode_in, notify: cfg_notify, endless: (cyc_count == '0)};
            tgt_d  = tgt_time;
            pw_d   = pw_c;
            cw_d   = cw_c;
            pat_d  = pat_word;
            cnt_d  = cyc_count;
            act_d  = 1'b0;
            idx_d  = '0;
            pin_d  = idle_level(mode_in);
            done_d = 1'b0;
            err_d  = 1'b0;
            if (late && !cfg_now) begin
                err_d = cfg_notify;
                st_d  = ST_IDLE;
            end else begin
                st_d  = ST_WAIT;
            end
        end else begin
            case (st_q)
                ST_WAIT: if (reached) begin
                    if (cfg_q.mode == WV_SERIAL) begin
                        pin_d    = pat_q[0];
                        idx_d    = (PATW > 1) ? IW'(1) : '0;
                        ld       = 1'b1;
                        ld_width = cw_q;
                        st_d     = ST_RUN;
                    end else if (is_pulse(cfg_q.mode) || is_cycle(cfg_q.mode)) begin
                        pin_d    = act_lvl;
                        act_d    = 1'b1;
                        ld       = 1'b1;
                        ld_width = pw_q;
                        st_d     = ST_RUN;
                    end else begin
                        pin_d    = act_lvl;
                        done_d   = cfg_q.notify;
                        st_d     = ST_IDLE;
                    end
                end
                ST_RUN: if (expire) begin
                    if (is_pulse(cfg_q.mode)) begin
                        pin_d  = idle_lvl;
                        done_d = cfg_q.notify;
                        st_d   = ST_IDLE;
                    end else if (is_cycle(cfg_q.mode)) begin
                        if (act_q && last_unit) begin
                            pin_d  = idle_lvl;
                            done_d = cfg_q.notify;
                            st_d   = ST_IDLE;
                        end else if (act_q) begin
                            if (!cfg_q.endless) cnt_d = cnt_q - CW'(1);
                            pin_d    = idle_lvl;
                            act_d    = 1'b0;
                            ld       = 1'b1;
                            ld_width = cw_q - pw_q;
                        end else begin
                            pin_d    = act_lvl;
                            act_d    = 1'b1;
                            ld       = 1'b1;
                            ld_width = pw_q;
                        end
                    end else begin
                        if (last_unit) begin
                            pin_d  = 1'b0;
                            done_d = cfg_q.notify;
                            st_d   = ST_IDLE;
                        end else begin
                            if (!cfg_q.endless) cnt_d = cnt_q - CW'(1);
                            pin_d    = pat_q[idx_q];
                            idx_d    = (idx_q == LAST) ? '0 : idx_q + IW'(1);
                            ld       = 1'b1;
                            ld_width = cw_q;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cfg_q  <= '{mode: WV_RISE, notify: 1'b0, endless: 1'b0};
            act_q  <= 1'b0;
            cnt_q  <= '0;
            idx_q  <= '0;
            pat_q  <= '0;
            pw_q   <= MIN_V;
            cw_q   <= MIN_V;
            tgt_q  <= '0;
            pin_q  <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            cfg_q  <= cfg_d;
            act_q  <= act_d;
            cnt_q  <= cnt_d;
            idx_q  <= idx_d;
            pat_q  <= pat_d;
            pw_q   <= pw_d;
            cw_q   <= cw_d;
            tgt_q  <= tgt_d;
            pin_q  <= pin_d;
            done_q <= done_d;
            err_q  <= err_d;
        end
    end

    assign tgt_held = tgt_q;
    assign pin      = pin_q;
    assign done     = done_q;
    assign err      = err_q;

    // R10
    notify_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.notify |-> (!done_q && !err_q));

    // R9
    err_no_fire_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q) |-> (st_q == ST_IDLE));

    // R2
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WAIT && !reached && !arm && !sw_rst) |=> (st_q == ST_WAIT && $stable(pin_q)));

    // R12
    swrst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        sw_rst |=> (!done_q && !err_q && st_q == ST_IDLE));
endmodule

// File: rtl/trig_wavegen.sv
`timescale 1ns/1ps
module trig_wavegen #(
    parameter int TW       = 64,
    parameter int WW       = 32,
    parameter int CW       = 16,
    parameter int PATW     = 16,
    parameter int STEP_NS  = 8,
    parameter int MIN_W_NS = 40
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [TW-1:0]   sys_time,
    input  logic [TW-1:0]   tgt_time,
    input  logic [2:0]      cfg_mode,
    input  logic            cfg_now,
    input  logic            cfg_notify,
    input  logic [WW-1:0]   pulse_w,
    input  logic [WW-1:0]   cycle_w,
    input  logic [CW-1:0]   cyc_count,
    input  logic [PATW-1:0] pat_word,
    input  logic            arm,
    input  logic            sw_rst,
    output logic            pin_out,
    output logic            trig_done,
    output logic            trig_err
);
    logic [TW-1:0] tgt_held;
    logic          reached, late, ld, expire;
    logic [WW-1:0] ld_width;

    trig_time_cmp #(.TW(TW)) u_cmp (
        .sys_time (sys_time),
        .tgt_live (tgt_time),
        .tgt_held (tgt_held),
        .reached  (reached),
        .late     (late)
    );

    trig_phase_timer #(.WW(WW), .STEP_NS(STEP_NS), .MIN_W_NS(MIN_W_NS)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .ld       (ld),
        .ld_width (ld_width),
        .expire   (expire)
    );

    trig_seq_fsm #(.TW(TW), .WW(WW), .CW(CW), .PATW(PATW), .MIN_W_NS(MIN_W_NS)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .arm        (arm),
        .sw_rst     (sw_rst),
        .cfg_mode   (cfg_mode),
        .cfg_now    (cfg_now),
        .cfg_notify (cfg_notify),
        .tgt_time   (tgt_time),
        .pulse_w    (pulse_w),
        .cycle_w    (cycle_w),
        .cyc_count  (cyc_count),
        .pat_word   (pat_word),
        .late       (late),
        .reached    (reached),
        .expire     (expire),
        .tgt_held   (tgt_held),
        .ld         (ld),
        .ld_width   (ld_width),
        .pin        (pin_out),
        .done       (trig_done),
        .err        (trig_err)
    );
endmodule

// File: tb/trig_wavegen_tb.sv
`timescale 1ns/1ps
module trig_wavegen_tb;
    localparam int STEP = 10;
    localparam int NCAP = 128;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] sys_time;
    logic [63:0] tgt_time = '0;
    logic [2:0]  cfg_mode = 3'b001;
    logic        cfg_now = 1'b0, cfg_notify = 1'b0;
    logic [31:0] pulse_w = 32'd40, cycle_w = 32'd80;
    logic [15:0] cyc_count = '0, pat_word = '0;
    logic        arm = 1'b0, sw_rst = 1'b0;
    logic        pin_out, trig_done, trig_err;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic tr_pin [0:NCAP-1];
    logic tr_done[0:NCAP-1];
    logic tr_err [0:NCAP-1];

    trig_wavegen #(.STEP_NS(STEP), .MIN_W_NS(40)) u_dut (
        .clk(clk), .rst(rst), .sys_time(sys_time), .tgt_time(tgt_time),
        .cfg_mode(cfg_mode), .cfg_now(cfg_now), .cfg_notify(cfg_notify),
        .pulse_w(pulse_w), .cycle_w(cycle_w), .cyc_count(cyc_count),
        .pat_word(pat_word), .arm(arm), .sw_rst(sw_rst),
        .pin_out(pin_out), .trig_done(trig_done), .trig_err(trig_err)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) sys_time <= 64'd1000;
        else     sys_time <= sys_time + 64'(STEP);
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expect pin level over a run of samples, one check for the run
    task automatic chk_run(input int j0, input int len, input logic lvl, input string tag);
        bit ok = 1;
        int bad = j0;
        for (int j = j0; j < j0 + len; j++)
            if (ok && tr_pin[j] !== lvl) begin ok = 0; bad = j; end
        chk(ok, tag, 64'(tr_pin[bad]), 64'(lvl));
    endtask

    // Arm with target = current time + off; sample k shows state after k-th edge past arming
    task automatic arm_capture(input logic [2:0] m, input bit now, input bit ntf, input int off,
                               input int pw, input int cw, input int cnt, input logic [15:0] pat,
                               input int n);
        @(negedge clk);
        cfg_mode = m; cfg_now = now; cfg_notify = ntf;
        pulse_w = 32'(pw); cycle_w = 32'(cw); cyc_count = 16'(cnt); pat_word = pat;
        tgt_time = (off < 0) ? sys_time - 64'(-off) : sys_time + 64'(off);
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        tr_pin[0] = pin_out; tr_done[0] = trig_done; tr_err[0] = trig_err;
        for (int j = 1; j < n; j++) begin
            @(negedge clk);
            tr_pin[j] = pin_out; tr_done[j] = trig_done; tr_err[j] = trig_err;
        end
    endtask

    task automatic t_reset();
        chk(pin_out === 1'b0, "R1 pin", 64'(pin_out), 0);
        chk(trig_done === 1'b0, "R1 done", 64'(trig_done), 0);
        chk(trig_err === 1'b0, "R1 err", 64'(trig_err), 0);
    endtask

    task automatic t_fall_edge();
        arm_capture(3'b000, 0, 1, 50, 40, 80, 0, 0, 20);
        chk_run(0, 5, 1'b1, "R2 idle high then wait");
        chk_run(5, 15, 1'b0, "R3 falling edge holds low");
        chk(tr_done[4] === 1'b0 && tr_done[5] === 1'b1, "R3 done with edge",
            64'({tr_done[4], tr_done[5]}), 64'b01);
    endtask

    task automatic t_rise_edge_silent();
        arm_capture(3'b001, 0, 0, 30, 40, 80, 0, 0, 15);
        chk_run(0, 3, 1'b0, "R2 idle low");
        chk_run(3, 12, 1'b1, "R3 rising edge holds high");
        chk(tr_done[14] === 1'b0, "R10 done silent", 64'(tr_done[14]), 0);
    endtask

    task automatic t_low_pulse();
        arm_capture(3'b010, 0, 1, 20, 100, 80, 0, 0, 20);
        chk_run(0, 2, 1'b1, "R4 idle high");
        chk_run(2, 10, 1'b0, "R4 low pulse 100ns");
        chk_run(12, 8, 1'b1, "R4 back to idle");
        chk(tr_done[11] === 1'b0 && tr_done[12] === 1'b1, "R4 done on return",
            64'({tr_done[11], tr_done[12]}), 64'b01);
    endtask

    task automatic t_high_pulse_clamped();
        arm_capture(3'b011, 0, 1, 20, 10, 80, 0, 0, 14);
        chk_run(2, 4, 1'b1, "R11 short pulse widened to 4 clocks");
        chk_run(6, 8, 1'b0, "R4 high pulse ends");
    endtask

    task automatic t_high_cycle_finite();
        arm_capture(3'b101, 0, 1, 20, 50, 120, 3, 0, 45);
        chk_run(0, 2, 1'b0, "R5 idle low");
        for (int c = 0; c < 3; c++) begin
            chk_run(2 + 12*c, 5, 1'b1, "R5 active phase");
            if (c < 2) chk_run(7 + 12*c, 7, 1'b0, "R5 rest of period");
        end
        chk_run(31, 14, 1'b0, "R5 stops after count");
        chk(tr_done[30] === 1'b0 && tr_done[31] === 1'b1, "R5 done after last pulse",
            64'({tr_done[30], tr_done[31]}), 64'b01);
    endtask

    task automatic t_low_cycle_endless_then_swrst();
        bit ok = 1;
        int bad = 1;
        arm_capture(3'b100, 0, 1, 10, 30, 50, 0, 0, 70);
        chk(tr_pin[0] === 1'b1, "R2 idle high", 64'(tr_pin[0]), 1);
        for (int j = 1; j < 70; j++) begin
            logic e;
            e = (((j - 1) % 8) < 4) ? 1'b0 : 1'b1;
            if (ok && tr_pin[j] !== e) begin ok = 0; bad = j; end
        end
        chk(ok, "R11 clamped 4+4 clock period", 64'(bad), 0);
        chk(tr_done[69] === 1'b0, "R7 endless, no done", 64'(tr_done[69]), 0);
        // stop it mid-run, pin must park high
        @(negedge clk); sw_rst = 1'b1; cfg_mode = 3'b100;
        @(negedge clk); sw_rst = 1'b0;
        chk(pin_out === 1'b1 && trig_done === 1'b0 && trig_err === 1'b0, "R12 reset to idle",
            64'({pin_out, trig_done, trig_err}), 64'b100);
        ok = 1;
        for (int j = 0; j < 12; j++) begin
            @(negedge clk);
            if (pin_out !== 1'b1) ok = 0;
        end
        chk(ok, "R12 stays idle", 64'(pin_out), 1);
    endtask

    task automatic t_serial();
        localparam logic [15:0] PAT = 16'hA5C3;
        bit ok = 1;
        int bad = 1;
        arm_capture(3'b110, 0, 1, 10, 40, 35, 20, PAT, 90);
        chk(tr_pin[0] === 1'b0, "R2 idle low", 64'(tr_pin[0]), 0);
        for (int b = 0; b < 20; b++)
            for (int s = 0; s < 4; s++)
                if (ok && tr_pin[1 + 4*b + s] !== PAT[b % 16]) begin ok = 0; bad = 1 + 4*b + s; end
        chk(ok, "R6 lsb first, wrap, 4 clocks per bit", 64'(bad), 0);
        chk_run(81, 9, 1'b0, "R6 low after last bit");
        chk(tr_done[80] === 1'b0 && tr_done[81] === 1'b1, "R6 done after bits",
            64'({tr_done[80], tr_done[81]}), 64'b01);
    endtask

    task automatic t_immediate();
        arm_capture(3'b001, 1, 1, -50, 40, 80, 0, 0, 4);
        chk(tr_pin[0] === 1'b0 && tr_pin[1] === 1'b1, "R8 past target fires at once",
            64'({tr_pin[0], tr_pin[1]}), 64'b01);
        chk(tr_err[3] === 1'b0, "R8 no error", 64'(tr_err[3]), 0);
    endtask

    task automatic t_late_error();
        arm_capture(3'b000, 0, 1, -50, 40, 80, 0, 0, 20);
        chk_run(0, 20, 1'b1, "R9 late target does not fire");
        chk(tr_err[0] === 1'b1 && tr_done[19] === 1'b0, "R9 error flag",
            64'({tr_err[0], tr_done[19]}), 64'b10);
    endtask

    task automatic t_reserved();
        bit ok = 1;
        arm_capture(3'b111, 0, 0, 20, 40, 80, 0, 0, 20);
        chk_run(0, 20, 1'b1, "R13 pin unchanged");
        for (int j = 0; j < 20; j++) if (tr_err[j] !== 1'b1) ok = 0;
        chk(ok, "R13 error flag kept", 64'(tr_err[19]), 1);
    endtask

    task automatic t_late_silent();
        arm_capture(3'b001, 0, 0, -30, 40, 80, 0, 0, 10);
        chk_run(0, 10, 1'b0, "R9 late target silent idle");
        chk(tr_err[9] === 1'b0, "R10 error silent", 64'(tr_err[9]), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fall_edge();
        t_rise_edge_silent();
        t_low_pulse();
        t_high_pulse_clamped();
        t_high_cycle_finite();
        t_low_cycle_endless_then_swrst();
        t_serial();
        t_immediate();
        t_late_error();
        t_reserved();
        t_late_silent();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule